// File: doc/BRIEF.md
# Interleaved loop-nest iteration issuer

This block produces the (outer, inner) index pairs that a pipelined two-level loop nest hands to its datapath, with one candidate slot on every clock. The inner loop has an initiation interval (II) that may exceed one. Plain pipelining would leave II-1 empty slots between two inner iterations. This issuer instead fills those slots with iterations of the following outer-loop invocations. The slots of each II-cycle period go round-robin to consecutive outer indices. A new group of invocations starts only once the previous group has issued its final inner iteration.

A start pulse captures the outer trip count M, the inner trip count N, the II and an interleave limit. A limit of 0 allows as many concurrent invocations as II. A limit of 1 gives plain pipelined issue. A limit between 1 and II leaves the surplus slots of each period empty. The issued pairs leave on a valid/ready stream. While valid is high and ready is low, the pair and every internal counter hold, so no pair is ever dropped or repeated. An empty (invalid) slot never waits for ready. A one-cycle done pulse closes each run.

Top module: `loop_issue_top`

## Requirements
- R1: During and directly after reset, `iss_valid_o` and `run_done_o` are 0.
- R2: M, N, II and the limit are captured only at the cycle that accepts a start. Changing these inputs later in the run has no effect on the pairs issued.
- R3: Let D be the effective degree. With the limit at 0, D equals II. Cycle c after the start edge (c=0 is the first cycle) belongs to group g = c / (N·II), inner index i = (c / II) mod N and slot s = c mod II. When s < D and g·D+s < M, that cycle issues outer index g·D+s with inner index i. For example, with M=4, N=5 and II=2, cycles 0–9 issue outer indices 0 and 1 alternately, and cycles 10–19 issue outer indices 2 and 3.
- R4: With a limit of 1, exactly one pair issues per II-cycle period, in slot 0. Outer index j completes all N inner iterations before j+1 begins.
- R5: A limit k with 1 < k < II issues in slots 0..k-1 of each period and leaves slots k..II-1 empty. A limit larger than II behaves like a limit of 0.
- R6: When M is not a multiple of D, the last group has fewer invocations. The slots of the missing invocations carry no valid issue, but they still take their cycles.
- R7: While `iss_valid_o`=1 and `iss_ready_i`=0, the outer and inner outputs and the issue schedule hold. Every pair is accepted exactly once, in the R3 order.
- R8: `run_done_o` is high for exactly one cycle: the cycle after the pair (M-1, N-1) is accepted. `iss_valid_o` stays 0 afterwards until the next start.
- R9: A start pulse that arrives while a run is in progress is ignored.
- R10: A start with M=0 or N=0 issues nothing, and `run_done_o` pulses in the next cycle.
- R11: An II of 0 is treated as 1. With II of 1, a pair issues on every cycle that ready allows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Run request; accepted only when idle |
| outer_cnt_i | input | CNT_W | Outer trip count M |
| inner_cnt_i | input | CNT_W | Inner trip count N |
| ii_i | input | II_W | Inner initiation interval |
| ilv_limit_i | input | II_W | Interleave limit (0 = II) |
| iss_ready_i | input | 1 | Downstream ready |
| iss_valid_o | output | 1 | Pair valid |
| iss_outer_o | output | CNT_W | Outer index of the pair |
| iss_inner_o | output | CNT_W | Inner index of the pair |
| run_done_o | output | 1 | One-cycle end-of-run pulse |

## Verification
The hardest case to reach is back-pressure landing on a group boundary, or on the final pair, while empty slots surround the stalled one. A stall must freeze the schedule, but an empty slot must not wait. One run therefore drives ready from a pseudo-random coin with II=2 and a partial last group, and the scoreboard checks order and done timing without any cycle stamps. Other runs keep ready high and check the exact cycle of every pair. Several runs also scramble the configuration inputs, or fire a second start, while the run is in progress.

// File: rtl/loop_issue_pkg.sv
package loop_issue_pkg;

  // Effective interleave degree from a normalised II and a limit.
  function automatic int unsigned eff_degree(input int unsigned ii_n,
                                             input int unsigned lim);
    if (lim == 0 || lim > ii_n) return ii_n;
    return lim;
  endfunction

  // II of zero is treated as one.
  function automatic int unsigned norm_ii(input int unsigned ii);
    return (ii == 0) ? 1 : ii;
  endfunction

endpackage

// File: rtl/loop_issue_cfg.sv
module loop_issue_cfg #(
  parameter int CNT_W = 8,
  parameter int II_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture_i,
  input  logic [CNT_W-1:0] m_i,
  input  logic [CNT_W-1:0] n_i,
  input  logic [II_W-1:0]  ii_i,
  input  logic [II_W-1:0]  lim_i,
  output logic [CNT_W-1:0] m_q,
  output logic [CNT_W-1:0] n_q,
  output logic [II_W-1:0]  ii_q,
  output logic [II_W-1:0]  deg_q
);
  import loop_issue_pkg::*;

  logic [II_W-1:0] ii_n, deg_n;

  always_comb begin
    ii_n  = II_W'(norm_ii(int'(ii_i)));
    deg_n = II_W'(eff_degree(int'(ii_n), int'(lim_i)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q   <= '0;
      n_q   <= '0;
      ii_q  <= II_W'(1);
      deg_q <= II_W'(1);
    end else if (capture_i) begin
      m_q   <= m_i;
      n_q   <= n_i;
      ii_q  <= ii_n;
      deg_q <= deg_n;
    end
  end

  // R5 / R11: degree never exceeds II and neither is zero
  assert_deg_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (deg_q != 0) && (ii_q != 0) && (deg_q <= ii_q));

endmodule

// File: rtl/loop_issue_walk.sv
module loop_issue_walk #(
  parameter int CNT_W = 8,
  parameter int II_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             zero_req_i,
  input  logic [CNT_W-1:0] m_i,
  input  logic [CNT_W-1:0] n_i,
  input  logic [II_W-1:0]  ii_i,
  input  logic [II_W-1:0]  deg_i,
  input  logic             ready_i,
  output logic             launch_o,
  output logic             busy_o,
  output logic             valid_o,
  output logic [CNT_W-1:0] outer_o,
  output logic [CNT_W-1:0] inner_o,
  output logic             done_o
);
  localparam int WW = ((CNT_W > II_W) ? CNT_W : II_W) + 1;

  logic             busy_q, done_q;
  logic [II_W-1:0]  slot_q;
  logic [CNT_W-1:0] inner_q;
  logic [WW-1:0]    base_q;
  logic [WW-1:0]    outer_w;
  logic             live, advance, period_end, last_pair, inner_end;

  always_comb begin
    outer_w    = base_q + WW'(slot_q);
    live       = busy_q && (slot_q < deg_i) && (outer_w < WW'(m_i));
    advance    = busy_q && (!live || ready_i);
    period_end = (slot_q == ii_i - II_W'(1));
    inner_end  = (inner_q == n_i - CNT_W'(1));
    last_pair  = live && ready_i && inner_end &&
                 (outer_w == WW'(m_i) - WW'(1));
  end

  assign launch_o = start_i && !busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      slot_q  <= '0;
      inner_q <= '0;
      base_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (launch_o) begin
        slot_q  <= '0;
        inner_q <= '0;
        base_q  <= '0;
        if (zero_req_i) done_q <= 1'b1;
        else            busy_q <= 1'b1;
      end else if (advance) begin
        if (last_pair) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else if (period_end) begin
          slot_q <= '0;
          if (inner_end) begin
            inner_q <= '0;
            base_q  <= base_q + WW'(deg_i);
          end else begin
            inner_q <= inner_q + CNT_W'(1);
          end
        end else begin
          slot_q <= slot_q + II_W'(1);
        end
      end
    end
  end

  assign busy_o  = busy_q;
  assign valid_o = live;
  assign outer_o = outer_w[CNT_W-1:0];
  assign inner_o = inner_q;
  assign done_o  = done_q;

  // R7: a stalled pair holds
  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(outer_o) && $stable(inner_o)));

  // R5: slots beyond the degree are empty
  assert_spare_slot_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && (slot_q >= deg_i)) |-> !valid_o);

  // R8: done is a single-cycle pulse and the block is idle then
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_q && !valid_o));

  // R3: inner index stays inside the captured trip count
  assert_inner_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (inner_o < n_i));

endmodule

// File: rtl/loop_issue_top.sv
module loop_issue_top #(
  parameter int CNT_W = 8,
  parameter int II_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] outer_cnt_i,
  input  logic [CNT_W-1:0] inner_cnt_i,
  input  logic [II_W-1:0]  ii_i,
  input  logic [II_W-1:0]  ilv_limit_i,
  input  logic             iss_ready_i,
  output logic             iss_valid_o,
  output logic [CNT_W-1:0] iss_outer_o,
  output logic [CNT_W-1:0] iss_inner_o,
  output logic             run_done_o
);
  logic             launch, busy, zero_req;
  logic [CNT_W-1:0] m_q, n_q;
  logic [II_W-1:0]  ii_q, deg_q;

  assign zero_req = (outer_cnt_i == '0) || (inner_cnt_i == '0);

  loop_issue_cfg #(.CNT_W(CNT_W), .II_W(II_W)) cfg_i (
    .clk(clk), .rst_n(rst_n), .capture_i(launch),
    .m_i(outer_cnt_i), .n_i(inner_cnt_i), .ii_i(ii_i), .lim_i(ilv_limit_i),
    .m_q(m_q), .n_q(n_q), .ii_q(ii_q), .deg_q(deg_q)
  );

  loop_issue_walk #(.CNT_W(CNT_W), .II_W(II_W)) walk_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .zero_req_i(zero_req),
    .m_i(m_q), .n_i(n_q), .ii_i(ii_q), .deg_i(deg_q),
    .ready_i(iss_ready_i), .launch_o(launch), .busy_o(busy),
    .valid_o(iss_valid_o), .outer_o(iss_outer_o), .inner_o(iss_inner_o),
    .done_o(run_done_o)
  );

  // R9 / R2: a start during a run leaves the captured configuration alone
  assert_busy_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(m_q) && $stable(n_q) && $stable(ii_q) && $stable(deg_q)));

endmodule

// File: tb/loop_issue_top_tb_top.sv
module loop_issue_top_tb_top;
  localparam int CNT_W = 8;
  localparam int II_W  = 4;

  logic clk = 0;
  logic rst_n = 0;
  logic start_i = 0;
  logic [CNT_W-1:0] outer_cnt_i = 0, inner_cnt_i = 0;
  logic [II_W-1:0]  ii_i = 0, ilv_limit_i = 0;
  logic iss_ready_i = 1;
  logic iss_valid_o, run_done_o;
  logic [CNT_W-1:0] iss_outer_o, iss_inner_o;

  always #5 clk = ~clk;

  loop_issue_top #(.CNT_W(CNT_W), .II_W(II_W)) dut_i (.*);

  typedef struct { int o; int i; int c; } exp_t;
  exp_t exp_q[$];

  int    n_total = 0, n_pass = 0;
  bit    timed = 1, bp_mode = 0, mon_running = 0, exp_done_next = 0;
  int    cyc = 0;
  string cur_req = "R3";
  bit    finished = 0;

  task automatic chk(bit ok, string req, string what, int act, int expv);
    n_total++;
    if (ok) n_pass++;
    else $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, expv, $time);
  endtask

  // back-pressure source
  always @(posedge clk) begin
    #2;
    iss_ready_i = bp_mode ? 1'($urandom % 2) : 1'b1;
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (!mon_running) begin
        chk(iss_valid_o == 0, "R8", "valid while idle", iss_valid_o, 0);
        chk(run_done_o == 0, "R8", "done while idle", run_done_o, 0);
        if (start_i) begin
          mon_running = 1;
          cyc = 0;
          exp_done_next = (exp_q.size() == 0);
        end
      end else begin
        chk(run_done_o == exp_done_next, exp_done_next ? cur_req : "R8",
            "done timing", run_done_o, exp_done_next);
        if (run_done_o || exp_done_next) begin
          mon_running = 0;
          exp_done_next = 0;
        end else if (iss_valid_o) begin
          if (exp_q.size() == 0) begin
            chk(0, "R7", "unexpected pair outer", iss_outer_o, -1);
          end else begin
            chk(iss_outer_o == exp_q[0].o, cur_req, "outer index", iss_outer_o, exp_q[0].o);
            chk(iss_inner_o == exp_q[0].i, cur_req, "inner index", iss_inner_o, exp_q[0].i);
            if (timed)
              chk(cyc == exp_q[0].c, cur_req, "issue cycle", cyc, exp_q[0].c);
            if (iss_ready_i) begin
              void'(exp_q.pop_front());
              if (exp_q.size() == 0) exp_done_next = 1;
            end
          end
        end
        cyc++;
      end
    end
  end

  // expected schedule from the requirements
  task automatic run(int m, int n, int ii, int lim, bit tm, bit bp, string req,
                     int extra_start_after);
    int iin = (ii == 0) ? 1 : ii;
    int d = (lim == 0 || lim > iin) ? iin : lim;
    if (m > 0 && n > 0)
      for (int g = 0; g * d < m; g++)
        for (int i = 0; i < n; i++)
          for (int s = 0; s < iin; s++)
            if (s < d && g * d + s < m)
              exp_q.push_back('{g * d + s, i, g * n * iin + i * iin + s});
    @(posedge clk); #2;
    timed = tm; bp_mode = bp; cur_req = req;
    outer_cnt_i = CNT_W'(m); inner_cnt_i = CNT_W'(n);
    ii_i = II_W'(ii); ilv_limit_i = II_W'(lim);
    start_i = 1;
    @(posedge clk); #2;
    start_i = 0;
    // R2: scramble configuration during the run
    outer_cnt_i = CNT_W'($urandom); inner_cnt_i = CNT_W'($urandom);
    ii_i = II_W'($urandom); ilv_limit_i = II_W'($urandom);
    if (extra_start_after > 0) begin
      repeat (extra_start_after) @(posedge clk);
      #2; start_i = 1;   // R9: ignored while busy
      @(posedge clk); #2; start_i = 0;
    end
    wait (!mon_running);
    bp_mode = 0;
    repeat (3) @(posedge clk);
    chk(exp_q.size() == 0, req, "pairs left over", exp_q.size(), 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_total++;
    $display("FAIL watchdog expired t=%0t", $time);
    $display("%0d/%0d checks passed", n_pass, n_total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(iss_valid_o == 0, "R1", "valid in reset", iss_valid_o, 0);
    chk(run_done_o == 0, "R1", "done in reset", run_done_o, 0);
    @(posedge clk); #2 rst_n = 1;
    @(negedge clk);
    chk(iss_valid_o == 0, "R1", "valid after reset", iss_valid_o, 0);
    chk(run_done_o == 0, "R1", "done after reset", run_done_o, 0);

    run(4, 5, 2, 0, 1, 0, "R3", 0);   // full interleave example
    run(3, 3, 3, 0, 1, 0, "R3", 0);
    run(3, 3, 3, 1, 1, 0, "R4", 0);   // plain pipelining
    run(4, 2, 4, 2, 1, 0, "R5", 0);   // partial degree
    run(5, 2, 3, 7, 1, 0, "R5", 0);   // limit above II clamps
    run(5, 3, 3, 0, 1, 0, "R6", 0);   // short last group
    run(7, 2, 4, 3, 1, 0, "R6", 0);
    run(2, 3, 0, 0, 1, 0, "R11", 0);  // II 0 acts as 1
    run(3, 4, 1, 0, 1, 0, "R11", 0);
    run(5, 4, 2, 0, 0, 1, "R7", 0);   // random back-pressure
    run(6, 3, 3, 2, 0, 1, "R7", 0);
    run(4, 3, 2, 0, 1, 0, "R9", 5);   // start during run
    run(3, 2, 2, 0, 1, 0, "R2", 0);   // config changed mid-run
    run(0, 4, 2, 0, 1, 0, "R10", 0);
    run(3, 0, 2, 0, 1, 0, "R10", 0);
    run(1, 1, 1, 0, 1, 0, "R8", 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_pass, n_total);
    $finish;
  end
endmodule